// File: doc/BRIEF.md
# Serial configuration loader

This block pushes a configuration image into a programmable target over a two-wire serial link. The loader is the clock master on that link. Image bytes come in on a valid/ready byte stream. A byte count, latched together with the start pulse, gives the image length. Every byte goes out unchanged, including any header bytes at the front of the image. Each byte is sent one bit per configuration clock, and the bit order within the byte can be selected. The data pin changes only while the configuration clock is low, so it is stable at the target's rising-edge sample point.

Before the first clock edge, the loader waits for the target's ready/error line to be high. After the last bit it keeps toggling the clock and watches two status lines. A high completion line means success. A low ready/error line means a CRC error. If a bounded number of extra pulses pass with neither, the result is a timeout. The result flag stays set until the next accepted start. If the byte stream runs dry during a load, the clock stops low, so no filler bits reach the target.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, busy, done_ok, crc_err, timeout, s_ready and cfg_clk are all 0.
- R2: With msb_first=0 at start, byte bit 0 is presented first and bit 7 last, and every received byte is sent unaltered, header bytes included.
- R3: With msb_first=1 at start, bit 7 is presented first. msb_first is sampled only at the accepted start, and later changes have no effect on the load.
- R4: cfg_dout changes only while cfg_clk is low and stays constant while cfg_clk is high. Inside a byte, consecutive rising edges of cfg_clk are 2*HALF_DIV system clocks apart (HALF_DIV >= 2).
- R5: start is accepted only when busy is 0. A start pulse while busy does not change the byte count, the bit order or the outcome of the running load.
- R6: After an accepted start, no cfg_clk edge occurs while tgt_init_n is low. If tgt_init_n stays low for READY_TMO cycles, the load ends with timeout=1 and no edges.
- R7: Each byte produces exactly 8 rising edges of cfg_clk. While no byte is available during a load, cfg_clk stays low.
- R8: After the last bit, cfg_clk keeps toggling. tgt_done=1 seen in this phase ends the load with done_ok=1.
- R9: tgt_init_n=0 seen after the last bit ends the load with crc_err=1. This takes priority over tgt_done in the same cycle.
- R10: If POST_MAX full clock pulses follow the last bit with neither status, the load ends with timeout=1. tgt_done seen in the same cycle as that limit gives done_ok instead.
- R11: Busy is 1 from the accepted start until exactly one result flag is set. The flag holds while idle and clears on the next accepted start.
- R12: A byte count of 0 sends no data bits and no stream handshake, and goes straight to the post-load pulse phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request pulse, accepted when idle |
| msb_first | input | 1 | Bit order select (0: bit 0 first, 1: bit 7 first), latched at start |
| byte_count | input | LEN_W | Image length in bytes, latched at start |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | s_data holds a byte |
| s_ready | output | 1 | Loader takes the byte this cycle when s_valid is 1 |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_dout | output | 1 | Serial configuration data to the target |
| tgt_done | input | 1 | Target completion status, high when configured |
| tgt_init_n | input | 1 | Target ready (high) / CRC error (low) |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Last load completed |
| crc_err | output | 1 | Last load ended with CRC error |
| timeout | output | 1 | Last load hung or target never became ready |

## Verification
The post-load decode can see several decisions in one cycle. The pulse limit can be reached in the same cycle that tgt_done rises, and tgt_done can rise in the same cycle that tgt_init_n falls. The bench provokes the first case by raising tgt_done just after the falling clock edge that completes the last permitted pulse. It provokes the second by moving both status lines on the same system clock. It judges each case by which single result flag appears, with success over timeout and CRC error over success, and by the number of clock pulses the target received.

// File: rtl/cfg_ld_pkg.sv
`timescale 1ns/1ps
package cfg_ld_pkg;
  localparam int BYTE_W = 8;
  localparam int BITS_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_INIT, ST_SHIFT, ST_POST} ld_state_e;
  typedef enum logic [1:0] {RES_NONE, RES_OK, RES_CRC, RES_TMO} ld_result_e;

  // bit presented on the data pin for the current shift register content
  function automatic logic head_bit(input logic [BYTE_W-1:0] sr, input logic msb);
    return msb ? sr[BYTE_W-1] : sr[0];
  endfunction

  // shift register content after one bit has been sent
  function automatic logic [BYTE_W-1:0] drop_bit(input logic [BYTE_W-1:0] sr, input logic msb);
    return msb ? {sr[BYTE_W-2:0], 1'b0} : {1'b0, sr[BYTE_W-1:1]};
  endfunction

  // post-load decode: error before success before pulse limit
  function automatic ld_result_e post_verdict(input logic init_n, input logic done, input logic at_limit);
    if (!init_n)      return RES_CRC;
    else if (done)    return RES_OK;
    else if (at_limit) return RES_TMO;
    else              return RES_NONE;
  endfunction
endpackage

// File: rtl/cfg_clk_gen.sv
`timescale 1ns/1ps
module cfg_clk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_ready,
  output logic cfg_clk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          advance;
  logic          wrap;

  // the low phase only runs when a bit is waiting; the high phase always completes
  assign advance  = run && (cfg_clk || bit_ready);
  assign wrap     = (cnt == CW'(HALF_DIV - 1));
  assign rise_evt = advance && wrap && !cfg_clk;
  assign fall_evt = advance && wrap && cfg_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cfg_clk <= 1'b0;
    end else if (!advance) begin
      cnt     <= '0;
      cfg_clk <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      cfg_clk <= ~cfg_clk;
    end else begin
      cnt     <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/cfg_shifter.sv
`timescale 1ns/1ps
module cfg_shifter
  import cfg_ld_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LEN_W-1:0]  count_in,
  input  logic              msb_in,
  input  logic              shifting,
  input  logic              fall_evt,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              bit_ready,
  output logic              image_sent,
  output logic              cfg_dout
);
  logic [BYTE_W-1:0] sr;
  logic [BITS_W-1:0] bits_left;
  logic [LEN_W-1:0]  bytes_left;
  logic              msb_q;
  logic              load;
  logic              step;

  assign s_ready    = shifting && (bits_left == '0) && (bytes_left != '0);
  assign load       = s_ready && s_valid;
  assign bit_ready  = (bits_left != '0);
  assign image_sent = (bits_left == '0) && (bytes_left == '0);
  assign step       = shifting && fall_evt && bit_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      bits_left  <= '0;
      bytes_left <= '0;
      msb_q      <= 1'b0;
      cfg_dout   <= 1'b0;
    end else if (arm) begin
      bytes_left <= count_in;
      msb_q      <= msb_in;
      bits_left  <= '0;
    end else if (load) begin
      sr         <= s_data;
      bits_left  <= BITS_W'(BYTE_W);
      bytes_left <= bytes_left - LEN_W'(1);
      cfg_dout   <= head_bit(s_data, msb_q);
    end else if (step) begin
      sr         <= drop_bit(sr, msb_q);
      bits_left  <= bits_left - BITS_W'(1);
      cfg_dout   <= head_bit(drop_bit(sr, msb_q), msb_q);
    end
  end
endmodule

// File: rtl/cfg_ctrl.sv
`timescale 1ns/1ps
module cfg_ctrl
  import cfg_ld_pkg::*;
#(
  parameter int READY_TMO = 4096,
  parameter int POST_MAX  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic image_sent,
  input  logic fall_evt,
  input  logic tgt_done,
  input  logic tgt_init_n,
  output logic arm,
  output logic shifting,
  output logic post_phase,
  output logic busy,
  output logic done_ok,
  output logic crc_err,
  output logic timeout
);
  localparam int RW = $clog2(READY_TMO + 1);
  localparam int PW = $clog2(POST_MAX + 1);

  ld_state_e  state;
  logic [RW-1:0] wait_cnt;
  logic [PW-1:0] post_cnt;
  logic          wait_expired;
  logic          post_limit;
  ld_result_e    verdict;

  assign arm          = start && (state == ST_IDLE);
  assign shifting     = (state == ST_SHIFT);
  assign post_phase   = (state == ST_POST);
  assign busy         = (state != ST_IDLE);
  assign wait_expired = (wait_cnt == RW'(READY_TMO));
  assign post_limit   = (post_cnt == PW'(POST_MAX));
  assign verdict      = post_verdict(tgt_init_n, tgt_done, post_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
      post_cnt <= '0;
      done_ok  <= 1'b0;
      crc_err  <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_WAIT_INIT;
            wait_cnt <= '0;
            done_ok  <= 1'b0;
            crc_err  <= 1'b0;
            timeout  <= 1'b0;
          end
        end
        ST_WAIT_INIT: begin
          if (tgt_init_n) begin
            state    <= ST_SHIFT;
            post_cnt <= '0;
          end else if (wait_expired) begin
            timeout  <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            wait_cnt <= wait_cnt + RW'(1);
          end
        end
        ST_SHIFT: begin
          if (image_sent) state <= ST_POST;
        end
        ST_POST: begin
          unique case (verdict)
            RES_CRC: begin crc_err <= 1'b1; state <= ST_IDLE; end
            RES_OK:  begin done_ok <= 1'b1; state <= ST_IDLE; end
            RES_TMO: begin timeout <= 1'b1; state <= ST_IDLE; end
            default: if (fall_evt) post_cnt <= post_cnt + PW'(1);
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader #(
  parameter int HALF_DIV  = 4,
  parameter int LEN_W     = 16,
  parameter int READY_TMO = 4096,
  parameter int POST_MAX  = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          msb_first,
  input  logic [LEN_W-1:0]              byte_count,
  input  logic [cfg_ld_pkg::BYTE_W-1:0] s_data,
  input  logic                          s_valid,
  output logic                          s_ready,
  output logic                          cfg_clk,
  output logic                          cfg_dout,
  input  logic                          tgt_done,
  input  logic                          tgt_init_n,
  output logic                          busy,
  output logic                          done_ok,
  output logic                          crc_err,
  output logic                          timeout
);
  // named internal events, visible to the bound checker
  logic arm;
  logic shifting;
  logic post_phase;
  logic image_sent;
  logic shift_bit_ready;
  logic clk_bit_ready;
  logic rise_evt;
  logic fall_evt;
  logic run;

  assign run           = shifting || post_phase;
  assign clk_bit_ready = post_phase || shift_bit_ready;

  cfg_ctrl #(
    .READY_TMO (READY_TMO),
    .POST_MAX  (POST_MAX)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .image_sent (image_sent),
    .fall_evt   (fall_evt),
    .tgt_done   (tgt_done),
    .tgt_init_n (tgt_init_n),
    .arm        (arm),
    .shifting   (shifting),
    .post_phase (post_phase),
    .busy       (busy),
    .done_ok    (done_ok),
    .crc_err    (crc_err),
    .timeout    (timeout)
  );

  cfg_shifter #(
    .LEN_W (LEN_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .count_in   (byte_count),
    .msb_in     (msb_first),
    .shifting   (shifting),
    .fall_evt   (fall_evt),
    .s_data     (s_data),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .bit_ready  (shift_bit_ready),
    .image_sent (image_sent),
    .cfg_dout   (cfg_dout)
  );

  cfg_clk_gen #(
    .HALF_DIV (HALF_DIV)
  ) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .bit_ready (clk_bit_ready),
    .cfg_clk   (cfg_clk),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt)
  );
endmodule

// File: rtl/cfg_ld_checker.sv
`timescale 1ns/1ps
module cfg_ld_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic s_ready,
  input logic cfg_clk,
  input logic cfg_dout,
  input logic busy,
  input logic done_ok,
  input logic crc_err,
  input logic timeout,
  input logic post_phase
);
  a_r4_dout_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk && $past(cfg_clk) |-> $stable(cfg_dout));

  a_r4_high_min_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) && busy |=> cfg_clk);

  a_r7_ready_only_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cfg_clk);

  a_r5_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !s_ready);

  a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done_ok, crc_err, timeout}) <= 1);

  a_r11_busy_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(done_ok || crc_err || timeout));

  a_r11_hold_ok: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && !start |=> done_ok);

  a_r11_hold_crc: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !start |=> crc_err);

  a_r11_hold_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !start |=> timeout);

  a_r6_clk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !cfg_clk);

  a_r9_crc_only_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(post_phase));
endmodule

bind serial_cfg_loader cfg_ld_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .s_ready    (s_ready),
  .cfg_clk    (cfg_clk),
  .cfg_dout   (cfg_dout),
  .busy       (busy),
  .done_ok    (done_ok),
  .crc_err    (crc_err),
  .timeout    (timeout),
  .post_phase (post_phase)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;
  localparam int HALF_DIV  = 2;
  localparam int LEN_W     = 8;
  localparam int READY_TMO = 30;
  localparam int POST_MAX  = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             msb_first = 1'b0;
  logic [LEN_W-1:0] byte_count = '0;
  logic [7:0]       s_data = '0;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic             cfg_clk;
  logic             cfg_dout;
  logic             tgt_done = 1'b0;
  logic             tgt_init_n = 1'b1;
  logic             busy, done_ok, crc_err, timeout;

  int checks = 0;
  int failures = 0;

  logic [7:0] img [0:15];
  int   n_img = 0;
  int   src_idx = 0;
  int   src_gap = 0;
  int   gap_left = 0;
  bit   pend = 1'b0;

  logic cap [0:255];
  time  rise_t [0:255];
  int   cap_n = 0;
  logic cap_last = 1'b0;
  int   dout_viol = 0;
  int   ready_seen = 0;

  always #2.5 clk = ~clk;

  serial_cfg_loader #(
    .HALF_DIV  (HALF_DIV),
    .LEN_W     (LEN_W),
    .READY_TMO (READY_TMO),
    .POST_MAX  (POST_MAX)
  ) i_serial_cfg_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .msb_first  (msb_first),
    .byte_count (byte_count),
    .s_data     (s_data),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .cfg_clk    (cfg_clk),
    .cfg_dout   (cfg_dout),
    .tgt_done   (tgt_done),
    .tgt_init_n (tgt_init_n),
    .busy       (busy),
    .done_ok    (done_ok),
    .crc_err    (crc_err),
    .timeout    (timeout)
  );

  // byte source, driven between clock edges
  always @(negedge clk) begin
    if (pend) begin
      src_idx  = src_idx + 1;
      gap_left = src_gap;
    end
    if (src_idx < n_img && gap_left == 0) begin
      s_valid = 1'b1;
      s_data  = img[src_idx];
    end else begin
      s_valid = 1'b0;
      if (gap_left > 0) gap_left = gap_left - 1;
    end
    pend = s_valid && s_ready;
    if (s_ready) ready_seen++;
    if (cfg_clk && cap_n > 0 && cfg_dout !== cap_last) dout_viol++;
  end

  // target side: capture the data bit on each rising configuration clock edge
  always @(posedge cfg_clk) begin
    if (cap_n < 256) begin
      cap[cap_n]    = cfg_dout;
      rise_t[cap_n] = $time;
    end
    cap_last = cfg_dout;
    cap_n++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bit_errors(input int nbytes, input bit msb);
    int e = 0;
    for (int i = 0; i < 8 * nbytes; i++) begin
      int b;
      int k;
      logic exp_bit;
      b = i / 8;
      k = i % 8;
      exp_bit = msb ? img[b][7-k] : img[b][k];
      if (cap[i] !== exp_bit) e++;
    end
    return e;
  endfunction

  task automatic launch(input bit msb, input int count, input int gap);
    @(negedge clk);
    cap_n = 0; src_idx = 0; gap_left = 0; pend = 1'b0;
    src_gap = gap; n_img = count; ready_seen = 0;
    msb_first = msb; byte_count = LEN_W'(count); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_cap(input int n);
    for (int i = 0; i < 4000 && cap_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    check(!busy, req, "load finished", busy, 0);
  endtask

  task automatic t_reset;
    check(!busy && !done_ok && !crc_err && !timeout, "R1", "flags after reset",
          {busy, done_ok, crc_err, timeout}, 0);
    check(!s_ready && !cfg_clk, "R1", "ready/clk after reset", {s_ready, cfg_clk}, 0);
  endtask

  task automatic t_lsb_order;
    img[0] = 8'hFF; img[1] = 8'hFF; img[2] = 8'hAA; img[3] = 8'h99; img[4] = 8'h55; img[5] = 8'h66;
    launch(1'b0, 6, 0);
    wait_cap(48 + 3);
    tgt_done = 1'b1;
    wait_idle("R8");
    tgt_done = 1'b0;
    check(done_ok && !crc_err && !timeout, "R8", "done_ok result", {done_ok, crc_err, timeout}, 4);
    check(cap_n == 51, "R8", "edges before done", cap_n, 51);
    check(bit_errors(6, 1'b0) == 0, "R2", "lsb-first bit errors", bit_errors(6, 1'b0), 0);
    check(rise_t[1] - rise_t[0] == 20, "R4", "rise spacing ns", int'(rise_t[1] - rise_t[0]), 20);
    check(dout_viol == 0, "R4", "dout change while clk high", dout_viol, 0);
  endtask

  task automatic t_hold_and_msb;
    repeat (30) @(negedge clk);
    check(done_ok && !busy, "R11", "result held while idle", {done_ok, busy}, 2);
    img[0] = 8'h01; img[1] = 8'h80; img[2] = 8'h3C; img[3] = 8'hA5;
    launch(1'b1, 4, 0);
    check(busy && !done_ok && !crc_err && !timeout, "R11", "start clears result",
          {busy, done_ok, crc_err, timeout}, 8);
    repeat (10) @(negedge clk);
    msb_first = 1'b0;
    wait_cap(32 + 1);
    tgt_done = 1'b1;
    wait_idle("R3");
    tgt_done = 1'b0;
    check(bit_errors(4, 1'b1) == 0, "R3", "msb-first bit errors", bit_errors(4, 1'b1), 0);
    check(done_ok, "R3", "msb load done", done_ok, 1);
  endtask

  task automatic t_stall;
    int held;
    img[0] = 8'hC3; img[1] = 8'h0F; img[2] = 8'h5A;
    launch(1'b0, 3, 80);
    wait_cap(8);
    repeat (30) @(negedge clk);
    held = cap_n;
    check(held == 8 && !cfg_clk, "R7", "no edges while stream dry", held, 8);
    wait_cap(24 + 1);
    tgt_done = 1'b1;
    wait_idle("R7");
    tgt_done = 1'b0;
    check(cap_n == 25, "R7", "edges with gaps", cap_n, 25);
    check(bit_errors(3, 1'b0) == 0, "R7", "bits across gaps", bit_errors(3, 1'b0), 0);
  endtask

  task automatic t_init_wait;
    img[0] = 8'h12; img[1] = 8'h34;
    tgt_init_n = 1'b0;
    launch(1'b0, 2, 0);
    repeat (20) @(negedge clk);
    check(cap_n == 0 && busy, "R6", "no edges before ready", cap_n, 0);
    tgt_init_n = 1'b1;
    wait_cap(17);
    tgt_done = 1'b1;
    wait_idle("R6");
    tgt_done = 1'b0;
    check(done_ok && bit_errors(2, 1'b0) == 0, "R6", "load after ready", done_ok, 1);
    tgt_init_n = 1'b0;
    launch(1'b0, 2, 0);
    wait_idle("R6");
    tgt_init_n = 1'b1;
    check(timeout && !done_ok && !crc_err, "R6", "ready timeout flag", timeout, 1);
    check(cap_n == 0, "R6", "edges during ready timeout", cap_n, 0);
  endtask

  task automatic t_crc;
    img[0] = 8'h77; img[1] = 8'h88; img[2] = 8'h99;
    launch(1'b0, 3, 0);
    wait_cap(24 + 2);
    tgt_init_n = 1'b0;
    wait_idle("R9");
    tgt_init_n = 1'b1;
    check(crc_err && !done_ok && !timeout, "R9", "crc result", {done_ok, crc_err, timeout}, 2);
    launch(1'b0, 3, 0);
    wait_cap(24 + 2);
    tgt_done = 1'b1;
    tgt_init_n = 1'b0;
    wait_idle("R9");
    tgt_done = 1'b0;
    tgt_init_n = 1'b1;
    check(crc_err && !done_ok, "R9", "crc beats done same cycle", {done_ok, crc_err, timeout}, 2);
  endtask

  task automatic t_post_timeout;
    img[0] = 8'hE1; img[1] = 8'h2D; img[2] = 8'hB4; img[3] = 8'h4B;
    launch(1'b0, 4, 0);
    wait_cap(10);
    @(negedge clk);
    start = 1'b1; byte_count = LEN_W'(1); msb_first = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R5", "busy after ignored start", busy, 1);
    wait_idle("R10");
    check(timeout && !done_ok && !crc_err, "R10", "pulse limit timeout", {done_ok, crc_err, timeout}, 1);
    check(cap_n == 32 + POST_MAX, "R10", "total edges", cap_n, 32 + POST_MAX);
    check(bit_errors(4, 1'b0) == 0, "R5", "order unchanged by ignored start", bit_errors(4, 1'b0), 0);
  endtask

  task automatic t_done_at_limit;
    img[0] = 8'h3E; img[1] = 8'hC1;
    launch(1'b0, 2, 0);
    wait_cap(16 + POST_MAX);
    @(negedge cfg_clk);
    #1 tgt_done = 1'b1;
    wait_idle("R10");
    tgt_done = 1'b0;
    check(done_ok && !timeout, "R10", "done wins at limit", {done_ok, crc_err, timeout}, 4);
  endtask

  task automatic t_zero;
    launch(1'b0, 0, 0);
    wait_idle("R12");
    check(timeout && cap_n == POST_MAX, "R12", "zero-length edges", cap_n, POST_MAX);
    check(ready_seen == 0, "R12", "no stream handshake", ready_seen, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_lsb_order();
    t_hold_and_msb();
    t_stall();
    t_init_wait();
    t_crc();
    t_post_timeout();
    t_done_at_limit();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule